// File: doc/BRIEF.md
# Row-Indexed Dirty Bit Tracker

This block holds the dirty state of a write-back cache in its own small table, separate from the tag store. The table is indexed by DRAM row, not by cache set. Each entry covers one DRAM row. It holds a valid flag, a row tag and a vector with one dirty bit per cache block of that row. A block address splits into a row number (upper bits) and a block offset inside the row (the low `log2(GRAN)` bits). The low bits of the row number select a set of the table.

The cache sends mark and clear updates keyed by block address. Two combinational queries read the table. One says whether a single block is dirty. The other returns the whole dirty vector of a row in one lookup.

When a mark arrives for a row that is not tracked and its set is full, the least recently marked entry of that set is replaced. The dirty blocks of the replaced entry then leave the block as writeback requests over a valid/ready port. They go out one per handshake, lowest offset first. Updates are refused until that drain ends.

Top module: `row_dirty_tracker`

## Requirements
- R1: After reset no row is tracked, every query reports clean with a zero vector, `wb_valid` is 0 and `upd_ready` is 1.
- R2: An accepted mark of block address A sets bit `A[OFF_W-1:0]` of the vector of row `A[ADDR_W-1:OFF_W]`. From the next cycle the line query of A reports dirty and the row query returns that bit. A mark to an untracked row with a free way allocates an entry holding only that bit.
- R3: A line query for a block whose row has no valid entry reports clean, and a row query for such a row reports `rq_hit` 0 with a zero vector.
- R4: An accepted clear resets the block's bit. When it clears the last set bit of an entry, the entry is freed, and the row query then reports `rq_hit` 0.
- R5: When `upd_mark` and `upd_clear` are both high in one accepted update, the block ends up dirty.
- R6: A clear for a row that is not tracked changes nothing and allocates no entry.
- R7: Up to WAYS rows whose row numbers share their low `log2(SETS)` bits are tracked at once without loss.
- R8: A mark to an untracked row in a full set replaces the way marked least recently. The replaced entry's dirty blocks are emitted on `wb_addr` as {row, offset}, one per handshake, in ascending offset order. The new entry holds only the new bit.
- R9: While `wb_valid` is high and `wb_ready` is low, `wb_valid` and `wb_addr` hold.
- R10: While a drain is in progress `upd_ready` is 0, and an update offered then has no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update offered |
| upd_ready | output | 1 | Update can be accepted (no drain in progress) |
| upd_addr | input | ADDR_W | Block address of the update |
| upd_mark | input | 1 | Set the block's dirty bit |
| upd_clear | input | 1 | Clear the block's dirty bit |
| lq_addr | input | ADDR_W | Block address for the line query |
| lq_dirty | output | 1 | Queried block is dirty |
| rq_row | input | ADDR_W-OFF_W | Row number for the row query |
| rq_hit | output | 1 | Queried row is tracked |
| rq_vec | output | GRAN | Dirty vector of the queried row |
| wb_valid | output | 1 | Writeback request present |
| wb_ready | input | 1 | Writeback request taken |
| wb_addr | output | ADDR_W | Block address to write back |

## Verification
The bench builds row vectors from scattered offsets, including a combined mark-and-clear and clears that touch tracked and untracked rows. This separates a correct bit update from a wrong offset and from a wrongly allocated entry. It fills one set past its ways twice, after changing which row was marked most recently. So a correct LRU victim gives a different writeback stream from a round-robin or fixed choice. The second drain runs under backpressure with an update offered while it runs. That shows whether the request is held, whether the order is ascending, and whether a stalled update leaks into the table.

// File: rtl/row_dirty_tracker.sv
module row_dirty_tracker #(
  parameter int ADDR_W = 12,
  parameter int GRAN   = 8,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            upd_valid,
  output logic                            upd_ready,
  input  logic [ADDR_W-1:0]               upd_addr,
  input  logic                            upd_mark,
  input  logic                            upd_clear,
  input  logic [ADDR_W-1:0]               lq_addr,
  output logic                            lq_dirty,
  input  logic [ADDR_W-$clog2(GRAN)-1:0]  rq_row,
  output logic                            rq_hit,
  output logic [GRAN-1:0]                 rq_vec,
  output logic                            wb_valid,
  input  logic                            wb_ready,
  output logic [ADDR_W-1:0]               wb_addr
);
  localparam int OFF_W = $clog2(GRAN);
  localparam int ROW_W = ADDR_W - OFF_W;
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ROW_W - SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic             valid_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [GRAN-1:0]  vec_q   [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];

  logic             dr_act;
  logic [ROW_W-1:0] dr_row;
  logic [GRAN-1:0]  dr_vec;
  logic [OFF_W-1:0] dr_off;

  wire [ROW_W-1:0] u_row = upd_addr[ADDR_W-1:OFF_W];
  wire [SET_W-1:0] u_set = u_row[SET_W-1:0];
  wire [TAG_W-1:0] u_tag = u_row[ROW_W-1:SET_W];
  wire [OFF_W-1:0] u_off = upd_addr[OFF_W-1:0];
  wire [GRAN-1:0]  u_bit = GRAN'(1) << u_off;
  wire             acc   = upd_valid && upd_ready;

  logic u_hit, u_free;
  logic [WAY_W-1:0] hit_way, free_way, lru_way, touch_way;
  logic do_touch;

  always_comb begin
    u_hit = 1'b0; u_free = 1'b0;
    hit_way = '0; free_way = '0; lru_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (valid_q[u_set][w] && tag_q[u_set][w] == u_tag) begin
        u_hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (!valid_q[u_set][w]) begin
        u_free = 1'b1; free_way = WAY_W'(w);
      end
      if (age_q[u_set][w] == WAY_W'(WAYS-1)) lru_way = WAY_W'(w);
    end
    do_touch  = acc && upd_mark;
    touch_way = u_hit ? hit_way : (u_free ? free_way : lru_way);
  end

  wire [ROW_W-1:0] l_row = lq_addr[ADDR_W-1:OFF_W];
  wire [SET_W-1:0] l_set = l_row[SET_W-1:0];
  wire [SET_W-1:0] r_set = rq_row[SET_W-1:0];

  always_comb begin
    lq_dirty = 1'b0; rq_hit = 1'b0; rq_vec = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_q[l_set][w] && tag_q[l_set][w] == l_row[ROW_W-1:SET_W])
        lq_dirty = vec_q[l_set][w][lq_addr[OFF_W-1:0]];
      if (valid_q[r_set][w] && tag_q[r_set][w] == rq_row[ROW_W-1:SET_W]) begin
        rq_hit = 1'b1; rq_vec = vec_q[r_set][w];
      end
    end
  end

  always_comb begin
    dr_off = '0;
    for (int b = GRAN-1; b >= 0; b--)
      if (dr_vec[b]) dr_off = OFF_W'(b);
  end

  assign upd_ready = !dr_act;
  assign wb_valid  = dr_act;
  assign wb_addr   = {dr_row, dr_off};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dr_act <= 1'b0; dr_row <= '0; dr_vec <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0; tag_q[s][w] <= '0;
          vec_q[s][w] <= '0;     age_q[s][w] <= WAY_W'(w);
        end
    end else begin
      if (dr_act && wb_ready) begin
        dr_vec[dr_off] <= 1'b0;
        if ((dr_vec & (dr_vec - GRAN'(1))) == '0) dr_act <= 1'b0;
      end
      if (acc && upd_mark) begin
        if (u_hit) begin
          vec_q[u_set][hit_way] <= vec_q[u_set][hit_way] | u_bit;
        end else begin
          if (!u_free) begin
            dr_act <= 1'b1;
            dr_row <= {tag_q[u_set][lru_way], u_set};
            dr_vec <= vec_q[u_set][lru_way];
          end
          valid_q[u_set][touch_way] <= 1'b1;
          tag_q[u_set][touch_way]   <= u_tag;
          vec_q[u_set][touch_way]   <= u_bit;
        end
      end else if (acc && upd_clear && u_hit) begin
        vec_q[u_set][hit_way] <= vec_q[u_set][hit_way] & ~u_bit;
        if ((vec_q[u_set][hit_way] & ~u_bit) == '0) valid_q[u_set][hit_way] <= 1'b0;
      end
      if (do_touch)
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == touch_way) age_q[u_set][w] <= '0;
          else if (age_q[u_set][w] < age_q[u_set][touch_way])
            age_q[u_set][w] <= age_q[u_set][w] + WAY_W'(1);
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));

  a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready |=> !wb_valid || (wb_addr > $past(wb_addr)));

  for (genvar gs = 0; gs < SETS; gs++) begin : g_set
    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
      a_r4_live_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[gs][gw] |-> vec_q[gs][gw] != '0);
      for (genvar gx = gw + 1; gx < WAYS; gx++) begin : g_pair
        a_r7_unique_row: assert property (@(posedge clk) disable iff (!rst_n)
          !(valid_q[gs][gw] && valid_q[gs][gx] && tag_q[gs][gw] == tag_q[gs][gx]));
      end
    end
  end
endmodule

// File: tb/sim_row_dirty_tracker.sv
module sim_row_dirty_tracker;
  localparam int ADDR_W = 12;
  localparam int GRAN   = 8;
  localparam int ROW_W  = ADDR_W - 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0, upd_mark = 1'b0, upd_clear = 1'b0, wb_ready = 1'b1;
  logic [ADDR_W-1:0] upd_addr = '0, lq_addr = '0;
  logic [ROW_W-1:0] rq_row = '0;
  logic upd_ready, lq_dirty, rq_hit, wb_valid;
  logic [GRAN-1:0] rq_vec;
  logic [ADDR_W-1:0] wb_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] expq[$];

  always #5 clk = ~clk;

  row_dirty_tracker #(.ADDR_W(ADDR_W), .GRAN(GRAN), .SETS(4), .WAYS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_addr(upd_addr), .upd_mark(upd_mark), .upd_clear(upd_clear),
    .lq_addr(lq_addr), .lq_dirty(lq_dirty), .rq_row(rq_row), .rq_hit(rq_hit),
    .rq_vec(rq_vec), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #4;
    if (rst_n && wb_valid && wb_ready) begin
      if (expq.size() == 0) check("R8 unexpected writeback", 32'(wb_addr), 32'hFFFF);
      else check("R8 writeback order", 32'(wb_addr), 32'(expq.pop_front()));
    end
  end

  task automatic upd(input logic [ADDR_W-1:0] a, input bit m, input bit c);
    @(negedge clk);
    while (!upd_ready) @(negedge clk);
    upd_addr = a; upd_mark = m; upd_clear = c; upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0; upd_mark = 1'b0; upd_clear = 1'b0;
  endtask

  task automatic qline(input logic [ADDR_W-1:0] a, input bit exp, input string req);
    @(negedge clk); lq_addr = a; #1;
    check(req, 32'(lq_dirty), 32'(exp));
  endtask

  task automatic qrow(input logic [ROW_W-1:0] r, input bit hit, input logic [GRAN-1:0] v,
                      input string req);
    @(negedge clk); rq_row = r; #1;
    check(req, {23'd0, rq_hit, rq_vec}, {23'd0, hit, v});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 upd_ready", 32'(upd_ready), 1);
    check("R1 wb_valid", 32'(wb_valid), 0);
    qline(12'h008, 0, "R1 line clean");
    qrow(9'd1, 0, 8'h00, "R3 untracked row");
    upd(12'h008, 1, 0);
    qline(12'h008, 1, "R2 line dirty");
    qline(12'h009, 0, "R3 neighbour clean");
    upd(12'h00D, 1, 0);
    qrow(9'd1, 1, 8'h21, "R2 row vector");
    upd(12'h00A, 1, 1);
    qline(12'h00A, 1, "R5 mark wins");
    upd(12'h00D, 0, 1);
    qrow(9'd1, 1, 8'h05, "R4 bit cleared");
    upd(12'h100, 0, 1);
    qrow(9'h20, 0, 8'h00, "R6 clear untracked");
    upd(12'h02F, 1, 0);
    qrow(9'd5, 1, 8'h80, "R7 second way");
    qrow(9'd1, 1, 8'h05, "R7 first way kept");
    upd(12'h009, 1, 0);
    expq.push_back(12'h02F);
    upd(12'h04A, 1, 0);
    @(negedge clk);
    while (wb_valid) @(negedge clk);
    check("R8 drain one", 32'(expq.size()), 0);
    qrow(9'd5, 0, 8'h00, "R8 victim gone");
    qrow(9'd9, 1, 8'h04, "R8 new entry single bit");
    qrow(9'd1, 1, 8'h07, "R8 recent row kept");
    wb_ready = 1'b0;
    expq.push_back(12'h008); expq.push_back(12'h009); expq.push_back(12'h00A);
    upd(12'h068, 1, 0);
    upd_addr = 12'h110; upd_mark = 1'b1; upd_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R9 wb held", {30'd0, wb_valid, 1'b0} | 32'(wb_addr), {30'd0, 1'b1, 1'b0} | 32'h008);
      check("R10 stalled", 32'(upd_ready), 0);
      @(negedge clk);
    end
    upd_valid = 1'b0; upd_mark = 1'b0;
    wb_ready = 1'b1;
    while (wb_valid) @(negedge clk);
    check("R8 drain three", 32'(expq.size()), 0);
    qrow(9'h22, 0, 8'h00, "R10 stalled update ignored");
    qrow(9'd13, 1, 8'h01, "R8 second new entry");
    qline(12'h04A, 1, "R2 row nine dirty");
    upd(12'h04A, 0, 1);
    qrow(9'd9, 0, 8'h00, "R4 entry freed");
    qline(12'h04A, 0, "R4 line clean after free");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule